// File: doc/BRIEF.md
# Single-Cycle Subset Processor Core

This block is a 32-bit processor core that completes each instruction in one clock period. It handles nine instructions: word load and store, five register-to-register operations (add, subtract, and, or, signed set-less-than), branch-if-equal and an unconditional jump. Every instruction is fetched, decoded, executed and written back within the same period. Program counter, register file and data memory all change state on the rising edge.

The core holds a small instruction memory and a small data memory as word arrays. Instruction fetch is combinational. Data memory reads are combinational and its writes land on the clock edge. A preload port fills either memory, and it is normally used while reset is held. The program counter, write-back bus and store bus are visible at the ports, so the instruction stream can be traced cycle by cycle.

Top module: `sc_core`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high at a rising edge, the program counter becomes 0. It is 0 in the cycle after that edge.
- R2: Instruction fields are decoded as opcode [31:26], first source [25:21], second source [20:16], destination [15:11] and function code [5:0]. Immediates are in [15:0] and the jump target is in [25:0]. Opcodes are 0 for register-to-register, 35 for load, 43 for store, 4 for branch-if-equal and 2 for jump.
- R3: Any instruction other than a taken branch or a jump moves the program counter to PC+4 at the next edge.
- R4: Register-to-register operations write the destination register [15:11] with the result. The function codes are 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, and 0x2A set-less-than. Set-less-than compares as signed and yields 1 or 0.
- R5: Register 0 always reads as zero, even after an instruction names it as its destination.
- R6: A load writes register [20:16] with the data word at address (first source + sign-extended immediate). The word index is address bits [N+1:2].
- R7: A store writes the register in [20:16] to the data word at (first source + sign-extended immediate) on the clock edge. `mem_we`, `mem_addr` and `mem_wdata` show the store during its cycle.
- R8: Branch-if-equal moves to PC+4+(sign-extended immediate × 4) when both sources are equal, and to PC+4 otherwise. It writes no register.
- R9: A jump moves to {PC+4 bits [31:28], target field, 2'b00}. It writes no register.
- R10: An instruction that reads the register it is writing sees the value from before the edge.
- R11: With `ld_en` high, `ld_data` is written at the edge into word `ld_addr`. The target is the data memory when `ld_dmem` is 1 and the instruction memory when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Preload write enable |
| ld_dmem | input | 1 | Preload target: 1 data memory, 0 instruction memory |
| ld_addr | input | LD_AW | Preload word index |
| ld_data | input | 32 | Preload word |
| pc | output | 32 | Current program counter |
| wb_en | output | 1 | Register write-back active this cycle |
| wb_reg | output | 5 | Register being written |
| wb_data | output | 32 | Value being written back |
| mem_we | output | 1 | Data memory store this cycle |
| mem_addr | output | 32 | Computed data address (ALU result) |
| mem_wdata | output | 32 | Store data |

## Verification
The bench builds the core with its default sizes: 32 instruction words, 16 data words and a 5-bit preload index. With these sizes a forward branch, a jump over skipped words, a jump to itself and stores at several data words all fit in one short program. Preloaded data gives the signed operand needed for set-less-than, and a negative store offset exercises sign extension. A second reset with a replaced first instruction shows that the preload port works and that data memory keeps its contents through reset.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

    localparam int XLEN = 32;
    localparam int RIDX = 5;

    typedef enum logic [5:0] {
        OP_RTYPE = 6'd0,
        OP_J     = 6'd2,
        OP_BEQ   = 6'd4,
        OP_LW    = 6'd35,
        OP_SW    = 6'd43
    } opcode_e;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_AND,
        ALU_OR,
        ALU_ADD,
        ALU_SUB,
        ALU_SLT
    } alu_fn_e;

    typedef struct packed {
        logic      dst_rd;
        logic      src_imm;
        logic      wb_mem;
        logic      reg_we;
        logic      mem_we;
        logic      branch;
        logic      jump;
        alu_fn_e   alu_fn;
    } ctrl_t;

    typedef struct packed {
        logic [5:0]      op;
        logic [RIDX-1:0] rs;
        logic [RIDX-1:0] rt;
        logic [RIDX-1:0] rd;
        logic [4:0]      shamt;
        logic [5:0]      funct;
    } instr_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import cpu_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] funct,
    output ctrl_t      ctl
);

    always_comb begin
        ctl        = '0;
        ctl.alu_fn = ALU_ADD;
        case (op)
            OP_RTYPE: begin
                ctl.dst_rd = 1'b1;
                ctl.reg_we = 1'b1;
                case (funct)
                    FN_SUB:  ctl.alu_fn = ALU_SUB;
                    FN_AND:  ctl.alu_fn = ALU_AND;
                    FN_OR:   ctl.alu_fn = ALU_OR;
                    FN_SLT:  ctl.alu_fn = ALU_SLT;
                    default: ctl.alu_fn = ALU_ADD;
                endcase
            end
            OP_LW: begin
                ctl.src_imm = 1'b1;
                ctl.wb_mem  = 1'b1;
                ctl.reg_we  = 1'b1;
            end
            OP_SW: begin
                ctl.src_imm = 1'b1;
                ctl.mem_we  = 1'b1;
            end
            OP_BEQ: begin
                ctl.branch = 1'b1;
                ctl.alu_fn = ALU_SUB;
            end
            OP_J: begin
                ctl.jump = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int NREG = 32,
    parameter int DW   = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] waddr,
    input  logic [DW-1:0]           wdata,
    input  logic [$clog2(NREG)-1:0] ra1,
    input  logic [$clog2(NREG)-1:0] ra2,
    output logic [DW-1:0]           rd1,
    output logic [DW-1:0]           rd2
);

    localparam int AW = $clog2(NREG);

    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (waddr != AW'(0))) begin
            regs[waddr] <= wdata;
        end
    end

    assign rd1 = (ra1 == AW'(0)) ? '0 : regs[ra1];
    assign rd2 = (ra2 == AW'(0)) ? '0 : regs[ra2];

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import cpu_pkg::*;
#(
    parameter int DW = 32
) (
    input  alu_fn_e       fn,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y,
    output logic          zero
);

    always_comb begin
        case (fn)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(DW-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_core.sv
module sc_core
    import cpu_pkg::*;
#(
    parameter int IMEM_WORDS = 32,
    parameter int DMEM_WORDS = 16,
    parameter int LD_AW      = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic             ld_dmem,
    input  logic [LD_AW-1:0] ld_addr,
    input  logic [31:0]      ld_data,
    output logic [31:0]      pc,
    output logic             wb_en,
    output logic [4:0]       wb_reg,
    output logic [31:0]      wb_data,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata
);

    localparam int IA = $clog2(IMEM_WORDS);
    localparam int DA = $clog2(DMEM_WORDS);

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    logic [XLEN-1:0] instr;
    instr_t          fld;
    ctrl_t           ctl;
    logic [XLEN-1:0] rs_val, rt_val, simm, alu_b, alu_y, ld_word, wb_val;
    logic [XLEN-1:0] pc4, br_tgt, j_tgt, pc_next;
    logic [RIDX-1:0] wr_idx;
    logic            zero;

    // fetch
    assign instr = imem[pc[IA+1:2]];
    assign fld   = instr_t'(instr);

    sc_decode u_dec (
        .op    (fld.op),
        .funct (fld.funct),
        .ctl   (ctl)
    );

    assign wr_idx = ctl.dst_rd ? fld.rd : fld.rt;
    assign simm   = sext16(instr[15:0]);
    assign alu_b  = ctl.src_imm ? simm : rt_val;

    sc_regfile #(.NREG(1 << RIDX), .DW(XLEN)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (ctl.reg_we),
        .waddr (wr_idx),
        .wdata (wb_val),
        .ra1   (fld.rs),
        .ra2   (fld.rt),
        .rd1   (rs_val),
        .rd2   (rt_val)
    );

    sc_alu #(.DW(XLEN)) u_alu (
        .fn   (ctl.alu_fn),
        .a    (rs_val),
        .b    (alu_b),
        .y    (alu_y),
        .zero (zero)
    );

    // data memory: combinational read, edge write
    assign ld_word = dmem[alu_y[DA+1:2]];
    assign wb_val  = ctl.wb_mem ? ld_word : alu_y;

    always_ff @(posedge clk) begin
        if (ld_en && !ld_dmem) imem[ld_addr[IA-1:0]] <= ld_data;
    end

    always_ff @(posedge clk) begin
        if (ld_en && ld_dmem)  dmem[ld_addr[DA-1:0]] <= ld_data;
        else if (ctl.mem_we)   dmem[alu_y[DA+1:2]]   <= rt_val;
    end

    // next PC
    assign pc4    = pc + 32'd4;
    assign br_tgt = pc4 + {simm[XLEN-3:0], 2'b00};
    assign j_tgt  = {pc4[31:28], instr[25:0], 2'b00};

    always_comb begin
        if (ctl.jump)                 pc_next = j_tgt;
        else if (ctl.branch && zero)  pc_next = br_tgt;
        else                          pc_next = pc4;
    end

    always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else     pc <= pc_next;
    end

    assign wb_en     = ctl.reg_we;
    assign wb_reg    = wr_idx;
    assign wb_data   = wb_val;
    assign mem_we    = ctl.mem_we;
    assign mem_addr  = alu_y;
    assign mem_wdata = rt_val;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic        mem_we,
    input logic        wb_en
);

    logic [5:0]  op;
    logic [31:0] boff;
    logic [31:0] jdest;

    assign op    = instr[31:26];
    assign boff  = {{14{instr[15]}}, instr[15:0], 2'b00};
    assign jdest = {pc[31:28], instr[25:0], 2'b00};

    // R1
    a_r1_pc_clear: assert property (@(posedge clk) rst |=> pc == 32'd0);

    // R3
    a_r3_pc_step: assert property (@(posedge clk) disable iff (rst)
        (op != 6'd4 && op != 6'd2) |=> pc == $past(pc) + 32'd4);

    // R5
    a_r5_zero_read: assert property (@(posedge clk) disable iff (rst)
        (instr[25:21] == 5'd0) |-> rs_val == 32'd0);

    // R7
    a_r7_store_only: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> op == 6'd43);

    // R6 / R4: only loads and register ops write back
    a_r6_wb_source: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (op == 6'd0 || op == 6'd35));

    // R8
    a_r8_beq_taken: assert property (@(posedge clk) disable iff (rst)
        (op == 6'd4 && rs_val == rt_val) |=> pc == $past(pc) + 32'd4 + $past(boff));

    a_r8_beq_fall: assert property (@(posedge clk) disable iff (rst)
        (op == 6'd4 && rs_val != rt_val) |=> pc == $past(pc) + 32'd4);

    // R9 (pc upper nibble equals that of pc+4 within the memory range used)
    a_r9_jump: assert property (@(posedge clk) disable iff (rst)
        (op == 6'd2 && pc[31:28] == 4'd0) |=> pc == $past(jdest));

endmodule

bind sc_core sc_core_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .pc     (pc),
    .instr  (instr),
    .rs_val (rs_val),
    .rt_val (rt_val),
    .mem_we (mem_we),
    .wb_en  (wb_en)
);

// File: tb/sim_sc_core.sv
module sim_sc_core;

    localparam int CLK_PERIOD = 10;
    localparam int NROWS      = 21;

    typedef struct packed {
        logic [31:0] pc;
        logic        wen;
        logic [4:0]  wr;
        logic [31:0] wd;
        logic        mwe;
        logic [31:0] ma;
        logic [31:0] md;
    } row_t;

    // expected trace, one row per cycle after reset release
    localparam row_t TR [NROWS] = '{
        '{32'd0,  1'b1, 5'd1,  32'd5,        1'b0, 32'd0,  32'd0}, // R6
        '{32'd4,  1'b1, 5'd2,  32'd3,        1'b0, 32'd0,  32'd0}, // R6
        '{32'd8,  1'b1, 5'd3,  32'hFFFFFFF0, 1'b0, 32'd0,  32'd0}, // R6
        '{32'd12, 1'b1, 5'd4,  32'd8,        1'b0, 32'd0,  32'd0}, // R4 add
        '{32'd16, 1'b1, 5'd5,  32'd2,        1'b0, 32'd0,  32'd0}, // R4 sub
        '{32'd20, 1'b1, 5'd6,  32'd1,        1'b0, 32'd0,  32'd0}, // R4 and
        '{32'd24, 1'b1, 5'd7,  32'd7,        1'b0, 32'd0,  32'd0}, // R4 or
        '{32'd28, 1'b1, 5'd8,  32'd1,        1'b0, 32'd0,  32'd0}, // R4 slt signed
        '{32'd32, 1'b1, 5'd9,  32'd0,        1'b0, 32'd0,  32'd0}, // R4 slt
        '{32'd36, 1'b0, 5'd0,  32'd0,        1'b1, 32'd4,  32'd8}, // R7 neg offset
        '{32'd40, 1'b1, 5'd10, 32'd8,        1'b0, 32'd0,  32'd0}, // R7 read back
        '{32'd44, 1'b1, 5'd0,  32'd8,        1'b0, 32'd0,  32'd0}, // R5 write r0
        '{32'd48, 1'b1, 5'd11, 32'd5,        1'b0, 32'd0,  32'd0}, // R5 r0 still 0
        '{32'd52, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0}, // R8 not taken
        '{32'd56, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0}, // R8 taken
        '{32'd68, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0}, // R9 jump
        '{32'd80, 1'b0, 5'd0,  32'd0,        1'b1, 32'd12, 32'd2}, // R7
        '{32'd84, 1'b1, 5'd14, 32'd2,        1'b0, 32'd0,  32'd0}, // R6
        '{32'd88, 1'b1, 5'd2,  32'd6,        1'b0, 32'd0,  32'd0}, // R10
        '{32'd92, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0}, // R9 self jump
        '{32'd92, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0}  // R9
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic        ld_dmem = 1'b0;
    logic [4:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [31:0] pc;
    logic        wb_en;
    logic [4:0]  wb_reg;
    logic [31:0] wb_data;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sc_core #(.IMEM_WORDS(32), .DMEM_WORDS(16), .LD_AW(5)) u0 (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_dmem(ld_dmem),
        .ld_addr(ld_addr), .ld_data(ld_data), .pc(pc), .wb_en(wb_en),
        .wb_reg(wb_reg), .wb_data(wb_data), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [31:0] enc_j(input int tgt);
        return {6'd2, 26'(tgt)};
    endfunction

    function automatic string tag_of(input int i);
        case (i)
            0, 1, 2, 17:   return "R6";
            3, 4, 5, 6, 7, 8: return "R4";
            9, 10, 16:     return "R7";
            11, 12:        return "R5";
            13, 14:        return "R8";
            18:            return "R10";
            default:       return "R9";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    task automatic load(input bit dm, input int addr, input logic [31:0] data);
        ld_en   = 1'b1;
        ld_dmem = dm;
        ld_addr = 5'(addr);
        ld_data = data;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic check_row(input int i);
        string t;
        t = tag_of(i);
        chk(t, "pc", pc, TR[i].pc);
        chk(t, "wb_en", {31'd0, wb_en}, {31'd0, TR[i].wen});
        if (TR[i].wen) begin
            chk(t, "wb_reg", {27'd0, wb_reg}, {27'd0, TR[i].wr});
            chk(t, "wb_data", wb_data, TR[i].wd);
        end
        chk(t, "mem_we", {31'd0, mem_we}, {31'd0, TR[i].mwe});
        if (TR[i].mwe) begin
            chk(t, "mem_addr", mem_addr, TR[i].ma);
            chk(t, "mem_wdata", mem_wdata, TR[i].md);
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        // R11 preload through the port while reset is held
        load(1, 0, 32'd5);
        load(1, 1, 32'd3);
        load(1, 2, 32'hFFFFFFF0);
        load(0, 0,  enc_i(6'd35, 0, 1, 16'd0));
        load(0, 1,  enc_i(6'd35, 0, 2, 16'd4));
        load(0, 2,  enc_i(6'd35, 0, 3, 16'd8));
        load(0, 3,  enc_r(1, 2, 4, 6'h20));
        load(0, 4,  enc_r(1, 2, 5, 6'h22));
        load(0, 5,  enc_r(1, 2, 6, 6'h24));
        load(0, 6,  enc_r(1, 2, 7, 6'h25));
        load(0, 7,  enc_r(3, 1, 8, 6'h2A));
        load(0, 8,  enc_r(1, 3, 9, 6'h2A));
        load(0, 9,  enc_i(6'd43, 4, 4, 16'hFFFC));
        load(0, 10, enc_i(6'd35, 0, 10, 16'd4));
        load(0, 11, enc_r(1, 2, 0, 6'h20));
        load(0, 12, enc_r(0, 1, 11, 6'h20));
        load(0, 13, enc_i(6'd4, 1, 2, 16'd5));
        load(0, 14, enc_i(6'd4, 4, 10, 16'd2));
        load(0, 15, enc_r(1, 1, 12, 6'h20));
        load(0, 16, enc_r(1, 1, 12, 6'h20));
        load(0, 17, enc_j(20));
        load(0, 18, enc_r(1, 1, 12, 6'h20));
        load(0, 19, enc_r(1, 1, 12, 6'h20));
        load(0, 20, enc_i(6'd43, 0, 5, 16'd12));
        load(0, 21, enc_i(6'd35, 0, 14, 16'd12));
        load(0, 22, enc_r(2, 2, 2, 6'h20));
        load(0, 23, enc_j(23));

        // R1 reset state
        chk("R1", "pc in reset", pc, 32'd0);

        rst = 1'b0;
        for (int i = 0; i < NROWS; i++) begin
            check_row(i);
            @(negedge clk);
        end

        // R1 reset mid-run, R11 replace first instruction during reset
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "pc after reset", pc, 32'd0);
        load(0, 0, enc_r(0, 0, 1, 6'h20));
        rst = 1'b0;
        chk("R11", "pc", pc, 32'd0);
        chk("R11", "wb_reg", {27'd0, wb_reg}, 32'd1);
        chk("R11", "wb_data", wb_data, 32'd0);
        @(negedge clk);
        // data memory keeps the earlier store to word 1
        chk("R6", "pc", pc, 32'd4);
        chk("R6", "wb_data", wb_data, 32'd8);
        @(negedge clk);
        @(negedge clk);
        chk("R3", "pc", pc, 32'd12);
        chk("R11", "add r1+r2 with r1=0", wb_data, 32'd8);

        finish_run();
    end

endmodule